// File: doc/BRIEF.md
# Multicycle Vector Magnitude Estimator

This block estimates the length sqrt(a² + b²) of a vector whose two components arrive as signed integers. It avoids multipliers and true root extraction. It takes the absolute value of both components, then their larger and smaller magnitude. It forms the estimate from a subtract, an add and two right shifts, and finally clamps the result from below with a second max operation.

The work is done by a controller that steps through a fixed nine-step schedule. Four shared data registers hold the intermediate values. One absolute-value unit, one max unit and one min unit sit on two operand buses, and both max steps use the same max unit through its bus multiplexers. A caller holds both operands on the input ports and raises `start` for one cycle. Nine clock edges later the block raises `done` for a single cycle with the estimate on `mag`, then returns to idle.

Top module: `mag_est_fsmd`

## Requirements
- R1: After a synchronous reset with `rst` = 1, `done` is 0 and `mag` is 0 until a computation completes.
- R2: `op_a` and `op_b` are sampled at the rising edge where `start` = 1 while the block is idle. Later changes on those ports do not alter the result.
- R3: `done` first reads 1 after exactly nine rising edges counted from the sampling edge. It reads 0 after each of the eight edges in between.
- R4: `done` stays 1 for exactly one cycle, after which the block is idle.
- R5: During the `done` cycle, `mag` equals max(t2, x). Here x = max(|a|,|b|), y = min(|a|,|b|), t1 = x − (x >> 3) and t2 = t1 + (y >> 1), computed on 16-bit values.
- R6: `mag` reads 0 in every cycle where `done` is 0.
- R7: The magnitude of the most negative operand (−32768) saturates to 32767.
- R8: A `start` pulse while a computation is running, including the `done` cycle itself, is ignored and does not create a further `done`.
- R9: A `start` in the cycle right after `done` is accepted and completes nine edges later.
- R10: The result is never below x, the larger operand magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation when idle |
| op_a | input | 16 | First component, two's complement |
| op_b | input | 16 | Second component, two's complement |
| done | output | 1 | One-cycle result-valid pulse |
| mag | output | 16 | Unsigned magnitude estimate, zero unless `done` |

## Verification
The schedule has a single exit, so a controller that skips or repeats a step shows up as `done` arriving one edge early or late, and a stuck state shows up as `done` never arriving. A wrong register selection on either shared bus, for example the second max reading the wrong register, changes `mag` in the very `done` cycle of that computation. Operand pairs are chosen so that each shift, the subtract, the add and the final clamp move the expected value. Busy-time and done-time start pulses expose a controller that re-enters the schedule, because they produce an extra `done` within nine edges.

// File: rtl/mag_pkg.sv
package mag_pkg;

   localparam int NREG = 4;
   localparam int RIW  = $clog2(NREG);

   typedef enum logic [3:0] {
      ST_IDLE, ST_ABSA, ST_ABSB, ST_MAX1, ST_MIN,
      ST_SHX, ST_SHY, ST_SUB, ST_ADD, ST_MAX2, ST_DONE
   } step_e;

   typedef enum logic [3:0] {
      OP_NONE, OP_LOAD, OP_ABS, OP_MAX, OP_MIN,
      OP_SHX, OP_SHY, OP_SUB, OP_ADD
   } op_e;

   typedef struct packed {
      op_e            op;
      logic [RIW-1:0] srca;
      logic [RIW-1:0] srcb;
      logic [RIW-1:0] dst;
   } ctl_t;

endpackage

// File: rtl/mag_abs.sv
module mag_abs #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic [W-1:0] v,
   output logic [W-1:0] m
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};

   generate
      if (SAT) begin : g_sat
         always_comb begin
            if (v == MOST_NEG)  m = MAX_POS;
            else if (v[W-1])    m = ~v + 1'b1;
            else                m = v;
            if (!$isunknown(v))
               a_r7_abs_saturates: assert (m <= MAX_POS);
         end
      end else begin : g_wrap
         assign m = v[W-1] ? (~v + 1'b1) : v;
      end
   endgenerate
endmodule

// File: rtl/mag_pick.sv
module mag_pick #(
   parameter int W        = 16,
   parameter bit PICK_MAX = 1'b1
) (
   input  logic [W-1:0] p,
   input  logic [W-1:0] q,
   output logic [W-1:0] r
);
   generate
      if (PICK_MAX) begin : g_max
         assign r = (p >= q) ? p : q;
      end else begin : g_min
         assign r = (p <= q) ? p : q;
      end
   endgenerate
endmodule

// File: rtl/mag_ctrl.sv
module mag_ctrl
   import mag_pkg::*;
#(
   parameter int STEPS = 9
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  start,
   output ctl_t  ctl,
   output logic  busy_done
);
   localparam int CW = $clog2(STEPS + 2);

   step_e st, st_nx;

   always_comb begin
      unique case (st)
         ST_IDLE: st_nx = start ? ST_ABSA : ST_IDLE;
         ST_ABSA: st_nx = ST_ABSB;
         ST_ABSB: st_nx = ST_MAX1;
         ST_MAX1: st_nx = ST_MIN;
         ST_MIN:  st_nx = ST_SHX;
         ST_SHX:  st_nx = ST_SHY;
         ST_SHY:  st_nx = ST_SUB;
         ST_SUB:  st_nx = ST_ADD;
         ST_ADD:  st_nx = ST_MAX2;
         ST_MAX2: st_nx = ST_DONE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= ST_IDLE;
      else     st <= st_nx;
   end

   // schedule table: operation, bus A source, bus B source, destination
   always_comb begin
      ctl = '{op: OP_NONE, srca: '0, srcb: '0, dst: '0};
      unique case (st)
         ST_IDLE: if (start) ctl = '{op: OP_LOAD, srca: 2'd0, srcb: 2'd0, dst: 2'd0};
         ST_ABSA: ctl = '{op: OP_ABS, srca: 2'd0, srcb: 2'd0, dst: 2'd0};
         ST_ABSB: ctl = '{op: OP_ABS, srca: 2'd1, srcb: 2'd0, dst: 2'd1};
         ST_MAX1: ctl = '{op: OP_MAX, srca: 2'd0, srcb: 2'd1, dst: 2'd2};
         ST_MIN:  ctl = '{op: OP_MIN, srca: 2'd0, srcb: 2'd1, dst: 2'd3};
         ST_SHX:  ctl = '{op: OP_SHX, srca: 2'd2, srcb: 2'd0, dst: 2'd0};
         ST_SHY:  ctl = '{op: OP_SHY, srca: 2'd3, srcb: 2'd0, dst: 2'd1};
         ST_SUB:  ctl = '{op: OP_SUB, srca: 2'd2, srcb: 2'd0, dst: 2'd0};
         ST_ADD:  ctl = '{op: OP_ADD, srca: 2'd0, srcb: 2'd1, dst: 2'd0};
         ST_MAX2: ctl = '{op: OP_MAX, srca: 2'd0, srcb: 2'd2, dst: 2'd0};
         default: ;
      endcase
   end

   assign busy_done = (st == ST_DONE);

   // edge counter used only by the checks below
   logic [CW-1:0] lat_cnt;
   always_ff @(posedge clk) begin
      if (rst || st == ST_IDLE) lat_cnt <= '0;
      else                      lat_cnt <= lat_cnt + 1'b1;
   end

   a_r3_nine_edges: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DONE) |-> (lat_cnt == CW'(STEPS)));

   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (st != ST_IDLE) |=> (st != ST_ABSA));

   a_r4_done_returns_idle: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DONE) |=> (st == ST_IDLE));
endmodule

// File: rtl/mag_dpath.sv
module mag_dpath
   import mag_pkg::*;
#(
   parameter int W       = 16,
   parameter int X_SHIFT = 3,
   parameter int Y_SHIFT = 1,
   parameter bit SAT_ABS = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  ctl_t          ctl,
   input  logic [W-1:0]  in_a,
   input  logic [W-1:0]  in_b,
   output logic [W-1:0]  acc
);
   logic [W-1:0] rf [NREG];
   logic [W-1:0] bus_a, bus_b;
   logic [W-1:0] abs_o, max_o, min_o, alu_o;
   logic         wr;

   assign bus_a = rf[ctl.srca];
   assign bus_b = rf[ctl.srcb];

   mag_abs  #(.W(W), .SAT(SAT_ABS)) u_abs (.v(bus_a), .m(abs_o));
   mag_pick #(.W(W), .PICK_MAX(1'b1)) u_max (.p(bus_a), .q(bus_b), .r(max_o));
   mag_pick #(.W(W), .PICK_MAX(1'b0)) u_min (.p(bus_a), .q(bus_b), .r(min_o));

   always_comb begin
      wr    = 1'b1;
      alu_o = '0;
      unique case (ctl.op)
         OP_ABS:  alu_o = abs_o;
         OP_MAX:  alu_o = max_o;
         OP_MIN:  alu_o = min_o;
         OP_SHX:  alu_o = bus_a >> X_SHIFT;
         OP_SHY:  alu_o = bus_a >> Y_SHIFT;
         OP_SUB:  alu_o = bus_a - bus_b;
         OP_ADD:  alu_o = bus_a + bus_b;
         default: wr = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) rf[i] <= '0;
      end else if (ctl.op == OP_LOAD) begin
         rf[0] <= in_a;
         rf[1] <= in_b;
      end else if (wr) begin
         rf[ctl.dst] <= alu_o;
      end
   end

   assign acc = rf[0];

   a_r10_final_not_below_x: assert property (@(posedge clk) disable iff (rst)
      (ctl.op == OP_MAX && ctl.dst == '0) |=> (rf[0] >= rf[2]));

   a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
      (ctl.op == OP_LOAD) |=> (rf[0] == $past(in_a) && rf[1] == $past(in_b)));
endmodule

// File: rtl/mag_est_fsmd.sv
module mag_est_fsmd
   import mag_pkg::*;
#(
   parameter int W       = 16,
   parameter int X_SHIFT = 3,
   parameter int Y_SHIFT = 1,
   parameter bit SAT_ABS = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   output logic          done,
   output logic [W-1:0]  mag
);
   localparam int STEPS = 9;

   generate
      if (W < 4) begin : g_bad_w
         $error("mag_est_fsmd: W must be at least 4");
      end
      if (X_SHIFT < 1 || X_SHIFT >= W || Y_SHIFT < 1 || Y_SHIFT >= W) begin : g_bad_sh
         $error("mag_est_fsmd: shift amounts out of range");
      end
   endgenerate

   ctl_t         ctl;
   logic [W-1:0] acc;

   mag_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk(clk), .rst(rst), .start(start), .ctl(ctl), .busy_done(done)
   );

   mag_dpath #(.W(W), .X_SHIFT(X_SHIFT), .Y_SHIFT(Y_SHIFT), .SAT_ABS(SAT_ABS)) u_dp (
      .clk(clk), .rst(rst), .ctl(ctl), .in_a(op_a), .in_b(op_b), .acc(acc)
   );

   assign mag = done ? acc : '0;

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

// File: tb/sim_mag_est_fsmd.sv
module sim_mag_est_fsmd;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        done;
   logic [15:0] mag;
   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;   // 125 MHz

   mag_est_fsmd u0 (.clk(clk), .rst(rst), .start(start), .op_a(op_a),
                    .op_b(op_b), .done(done), .mag(mag));

   function automatic int model(int a, int b);
      int ma, mb, x, y, t1, t2;
      ma = (a < 0) ? ((a == -32768) ? 32767 : -a) : a;
      mb = (b < 0) ? ((b == -32768) ? 32767 : -b) : b;
      x  = (ma > mb) ? ma : mb;
      y  = (ma > mb) ? mb : ma;
      t1 = x - (x >> 3);
      t2 = t1 + (y >> 1);
      return (t2 > x) ? t2 : x;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // raise start with operands, pass the sampling edge, drop start
   task automatic launch(int a, int b);
      op_a = 16'(a); op_b = 16'(b); start = 1'b1;
      tick();
      start = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
      chk("R1 done after reset", int'(done), 0);
      chk("R1 mag after reset", int'(mag), 0);
   endtask

   task automatic t_run(int a, int b, string tag);
      launch(a, b);
      op_a = 16'h5A5A; op_b = 16'hA5A5;   // R2: must not matter
      for (int k = 1; k <= 8; k++) begin
         tick();
         chk({"R3 done low ", tag}, int'(done), 0);
         chk({"R6 mag zero ", tag}, int'(mag), 0);
      end
      tick();
      chk({"R3 done high ", tag}, int'(done), 1);
      chk({"R5 value ", tag}, int'(mag), model(a, b));
      tick();
      chk({"R4 done drops ", tag}, int'(done), 0);
   endtask

   task automatic t_busy_start();
      launch(3, 4);
      for (int k = 1; k <= 8; k++) begin
         if (k == 4) begin op_a = 16'd999; op_b = 16'd1; start = 1'b1; end
         tick();
         start = 1'b0;
         chk("R8 no early done", int'(done), 0);
      end
      tick();
      chk("R8 done on time", int'(done), 1);
      chk("R8 value intact", int'(mag), 5);
      for (int k = 0; k < 10; k++) begin
         tick();
         chk("R8 no extra done", int'(done), 0);
      end
   endtask

   task automatic t_done_start();
      launch(100, 100);
      for (int k = 1; k <= 9; k++) tick();
      chk("R5 value 100,100", int'(mag), 138);
      op_a = 16'd7; op_b = 16'd0; start = 1'b1;   // start during done cycle
      tick();
      start = 1'b0;
      for (int k = 0; k < 11; k++) begin
         chk("R8 done-cycle start ignored", int'(done), 0);
         tick();
      end
   endtask

   task automatic t_back_to_back();
      launch(3, 4);
      for (int k = 1; k <= 9; k++) tick();
      chk("R9 first done", int'(done), 1);
      tick();                                  // now idle
      launch(6, 8);
      for (int k = 1; k <= 8; k++) tick();
      chk("R9 not early", int'(done), 0);
      tick();
      chk("R9 second done", int'(done), 1);
      chk("R9 second value", int'(mag), 10);
      tick();
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_run(3, 4, "3,4");
      t_run(0, 0, "0,0");
      t_run(-5, 12, "-5,12");
      t_run(1000, -200, "1000,-200");
      t_run(-32768, 0, "R7 sat");
      chk("R7 saturated result", int'(mag), 0);
      t_run(-32768, -32768, "R7 both neg");
      t_run(32767, 1, "R10 clamp");
      t_busy_start();
      t_done_start();
      t_back_to_back();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule